// File: doc/BRIEF.md
# Dual-Port Collision Arbiter

This block sits between two independent ports of a shared memory array and decides which port keeps access when both target the same word at once. Each port presents an enable, a write strobe and an address. When both enables are active and the addresses are equal, the block grants the location to the port that got there first. It raises a busy flag to the other port and blocks that port's write strobe into the array. Reads are not blocked.

Busy is registered. It changes one clock after the input change that causes it. A grant is kept for as long as the collision lasts. A strap input selects master or slave mode. In master mode the busy flags come from the local arbitration. In slave mode the busy flags are taken from an upstream arbiter and the local decision is ignored. Several arbiters can therefore share one decision when the data path is made wider by placing arrays side by side.

Top module: `dpc_arbiter`

## Requirements
- R1: When the two enables are not both high, or when the addresses differ, no busy flag is raised in master mode. Busy goes low by the cycle after such an input, or stays low.
- R2: A port counts as first when in the previous cycle it was already enabled on the same address. If only one port is first when the collision begins, that port wins and busy is raised to the other port.
- R3: If neither port was first, or both were, the left port wins. In master mode the two busy flags are never high together.
- R4: While the collision lasts, the winning port keeps its grant, whatever the two write strobes do.
- R5: Busy is released one clock after the addresses stop matching or after either enable goes low.
- R6: Busy is taken from a register. A change at the inputs shows at the busy outputs after exactly one rising clock edge.
- R7: With `master_mode` = 1, each busy output is driven by the local arbitration result.
- R8: With `master_mode` = 0, each busy output follows its own busy input at once, and the local arbitration has no effect on any output.
- R9: A port's gated write (`*_wr_ok`) is its enable AND its write strobe while its busy output is low, and it is 0 while its busy output is high.
- R10: After reset no port holds a grant, so neither busy output is high in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | Strap: 1 = busy flags come from the local arbitration, 0 = busy flags are taken from the inputs |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port address |
| l_busy_in | input | 1 | Left busy from the upstream arbiter (slave mode) |
| l_busy_out | output | 1 | Busy flag to the left port |
| l_wr_ok | output | 1 | Gated left write strobe to the array |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port address |
| r_busy_in | input | 1 | Right busy from the upstream arbiter (slave mode) |
| r_busy_out | output | 1 | Busy flag to the right port |
| r_wr_ok | output | 1 | Gated right write strobe to the array |

## Verification
Directed patterns cover the main cases. Two ports on different addresses, or only one port enabled, show that busy appears only on a real collision. A left-first arrival and a right-first arrival show that the winner follows arrival order and not port identity, and a same-cycle arrival shows the fixed tie rule. Write strobes are toggled during a held collision to show that the grant stays. The collision is then ended once by an address change and once by an enable drop. A slave-mode pattern drives the busy inputs against a live collision, which shows that the local decision is ignored. A long random run on a four-word address space then gives frequent collisions, releases and re-arrivals, and every output is compared with the reference model on every clock.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_t;

   localparam int PORT_L = 0;
   localparam int PORT_R = 1;
endpackage

// File: rtl/dpc_match.sv
// Address comparator and arrival tracker: reports the collision and
// which ports were already parked on their address in the previous cycle.
module dpc_match #(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              hit,
   output logic              l_held,
   output logic              r_held
);
   logic              l_en_q, r_en_q;
   logic [ADDR_W-1:0] l_addr_q, r_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_en_q   <= 1'b0;
         r_en_q   <= 1'b0;
         l_addr_q <= '0;
         r_addr_q <= '0;
      end else begin
         l_en_q   <= l_en;
         r_en_q   <= r_en;
         l_addr_q <= l_addr;
         r_addr_q <= r_addr;
      end
   end

   assign hit    = l_en & r_en & (l_addr == r_addr);
   assign l_held = l_en & l_en_q & (l_addr == l_addr_q);
   assign r_held = r_en & r_en_q & (r_addr == r_addr_q);
endmodule

// File: rtl/dpc_owner.sv
// Grant register: picks a winner at the start of a collision and keeps it.
module dpc_owner #(
   parameter bit TIE_RIGHT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit,
   input  logic            l_held,
   input  logic            r_held,
   output dpc_pkg::owner_t owner_q
);
   import dpc_pkg::*;

   owner_t tie_owner;
   owner_t owner_d;

   generate
      if (TIE_RIGHT) begin : g_tie_r
         assign tie_owner = OWN_RIGHT;
      end else begin : g_tie_l
         assign tie_owner = OWN_LEFT;
      end
   endgenerate

   always_comb begin
      owner_d = owner_q;
      if (!hit) begin
         owner_d = OWN_NONE;
      end else if (owner_q == OWN_NONE) begin
         if (l_held && !r_held)      owner_d = OWN_LEFT;
         else if (r_held && !l_held) owner_d = OWN_RIGHT;
         else                        owner_d = tie_owner;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner_d;
   end
endmodule

// File: rtl/dpc_gate.sv
// Busy source selection (local or upstream) and write gating per port.
module dpc_gate (
   input  logic            master_mode,
   input  dpc_pkg::owner_t owner,
   input  logic [1:0]      en,
   input  logic [1:0]      wr,
   input  logic [1:0]      busy_in,
   output logic [1:0]      busy_out,
   output logic [1:0]      wr_ok
);
   import dpc_pkg::*;

   logic [1:0] loc_busy;
   assign loc_busy[PORT_L] = (owner == OWN_RIGHT);
   assign loc_busy[PORT_R] = (owner == OWN_LEFT);

   for (genvar p = 0; p < 2; p++) begin : g_port
      assign busy_out[p] = master_mode ? loc_busy[p] : busy_in[p];
      assign wr_ok[p]    = en[p] & wr[p] & ~busy_out[p];
   end
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter #(
   parameter int ADDR_W    = 14,
   parameter bit TIE_RIGHT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_busy_in,
   output logic              l_busy_out,
   output logic              l_wr_ok,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_busy_in,
   output logic              r_busy_out,
   output logic              r_wr_ok
);
   import dpc_pkg::*;

   initial begin : chk_params
      assert (ADDR_W >= 1 && ADDR_W <= 32)
         else $error("dpc_arbiter: ADDR_W out of range");
   end

   logic       hit, l_held, r_held;
   owner_t     owner;
   logic [1:0] busy_o, wr_o;

   dpc_match #(.ADDR_W(ADDR_W)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .l_en   (l_en),
      .l_addr (l_addr),
      .r_en   (r_en),
      .r_addr (r_addr),
      .hit    (hit),
      .l_held (l_held),
      .r_held (r_held)
   );

   dpc_owner #(.TIE_RIGHT(TIE_RIGHT)) u_owner (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .l_held  (l_held),
      .r_held  (r_held),
      .owner_q (owner)
   );

   dpc_gate u_gate (
      .master_mode (master_mode),
      .owner       (owner),
      .en          ({r_en, l_en}),
      .wr          ({r_wr, l_wr}),
      .busy_in     ({r_busy_in, l_busy_in}),
      .busy_out    (busy_o),
      .wr_ok       (wr_o)
   );

   assign l_busy_out = busy_o[PORT_L];
   assign r_busy_out = busy_o[PORT_R];
   assign l_wr_ok    = wr_o[PORT_L];
   assign r_wr_ok    = wr_o[PORT_R];
endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_mode,
   input logic              l_en,
   input logic              l_wr,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_busy_in,
   input logic              l_busy_out,
   input logic              l_wr_ok,
   input logic              r_en,
   input logic              r_wr,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_busy_in,
   input logic              r_busy_out,
   input logic              r_wr_ok
);
   logic clash;
   assign clash = l_en & r_en & (l_addr == r_addr);

   // R3: never both busy from local arbitration
   a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      master_mode |-> !(l_busy_out && r_busy_out));

   // R1 / R5: no collision means no busy one clock later
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && !clash) |=> (!master_mode || (!l_busy_out && !r_busy_out)));

   // R4: a held collision keeps the same loser busy
   a_r4_hold_l: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && clash && l_busy_out) |=> (!master_mode || l_busy_out));
   a_r4_hold_r: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && clash && r_busy_out) |=> (!master_mode || r_busy_out));

   // R8: slave mode passes busy through
   a_r8_slave_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |-> (l_busy_out == l_busy_in && r_busy_out == r_busy_in));

   // R9: busy port never writes; free port writes when it asks
   a_r9_block_l: assert property (@(posedge clk) disable iff (!rst_n)
      l_busy_out |-> !l_wr_ok);
   a_r9_block_r: assert property (@(posedge clk) disable iff (!rst_n)
      r_busy_out |-> !r_wr_ok);
   a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_busy_out && l_en && l_wr) |-> l_wr_ok);
   a_r9_pass_r: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_busy_out && r_en && r_wr) |-> r_wr_ok);
endmodule

bind dpc_arbiter dpc_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dpc_arbiter_bench.sv
`timescale 1ns/1ps
module dpc_arbiter_bench;
   localparam int AW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ms = 1'b1;
   logic          le = 1'b0, lw = 1'b0, lbi = 1'b0;
   logic          re = 1'b0, rw = 1'b0, rbi = 1'b0;
   logic [AW-1:0] la = '0, ra = '0;
   logic          lbo, lok, rbo, rok;

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_tag = "R10 reset";
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   dpc_arbiter u_dpc_arbiter (
      .clk(clk), .rst_n(rst_n), .master_mode(ms),
      .l_en(le), .l_wr(lw), .l_addr(la), .l_busy_in(lbi),
      .l_busy_out(lbo), .l_wr_ok(lok),
      .r_en(re), .r_wr(rw), .r_addr(ra), .r_busy_in(rbi),
      .r_busy_out(rbo), .r_wr_ok(rok)
   );

   // reference model: 0 none, 1 left holds, 2 right holds
   int            m_own = 0;
   logic          p_le = 1'b0, p_re = 1'b0;
   logic [AW-1:0] p_la = '0, p_ra = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_own = 0; p_le = 0; p_re = 0; p_la = '0; p_ra = '0;
      end else begin
         bit coll, lfirst, rfirst;
         coll   = le && re && (la == ra);
         lfirst = le && p_le && (la == p_la);
         rfirst = re && p_re && (ra == p_ra);
         if (!coll)          m_own = 0;
         else if (m_own == 0) m_own = (rfirst && !lfirst) ? 2 : 1;
         p_le = le; p_re = re; p_la = la; p_ra = ra;
      end
   end

   task automatic cmp1(string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", cur_tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic eb_l, eb_r;
      eb_l = ms ? (m_own == 2) : lbi;
      eb_r = ms ? (m_own == 1) : rbi;
      cmp1("l_busy_out", lbo, eb_l);
      cmp1("r_busy_out", rbo, eb_r);
      cmp1("l_wr_ok", lok, le & lw & ~eb_l);
      cmp1("r_wr_ok", rok, re & rw & ~eb_r);
   endtask

   // check outputs for the previous inputs, then apply the next ones
   task automatic cyc(string tag, logic m, logic e0, logic w0, int a0,
                      logic e1, logic w1, int a1, logic b0, logic b1);
      @(negedge clk);
      compare();
      cur_tag = tag;
      ms = m; le = e0; lw = w0; la = AW'(a0);
      re = e1; rw = w1; ra = AW'(a1); lbi = b0; rbi = b1;
   endtask

   initial begin : watchdog
      #(5.0 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      cyc("R10 reset", 1, 1, 1, 5, 1, 1, 5, 0, 0);
      cyc("R10 reset", 1, 1, 1, 5, 1, 1, 5, 0, 0);
      rst_n = 1'b1;
      cyc("R10 idle", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      // R1: different addresses, single enable
      cyc("R1 diff addr", 1, 1, 1, 3, 1, 1, 4, 0, 0);
      cyc("R1 diff addr", 1, 1, 1, 3, 1, 1, 4, 0, 0);
      cyc("R1 one enable", 1, 1, 1, 7, 0, 1, 7, 0, 0);
      cyc("R1 one enable", 1, 0, 1, 7, 1, 1, 7, 0, 0);
      cyc("R1 idle", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      // R2: left first, right arrives later
      cyc("R2 left first", 1, 1, 0, 9, 0, 0, 0, 0, 0);
      cyc("R2 left first", 1, 1, 0, 9, 1, 1, 9, 0, 0);
      cyc("R2 left first", 1, 1, 1, 9, 1, 1, 9, 0, 0);
      cyc("R4 hold wr toggle", 1, 1, 0, 9, 1, 0, 9, 0, 0);
      cyc("R4 hold wr toggle", 1, 1, 1, 9, 1, 1, 9, 0, 0);
      cyc("R5 addr change", 1, 1, 1, 9, 1, 1, 8, 0, 0);
      cyc("R5 addr change", 1, 1, 1, 9, 1, 1, 8, 0, 0);
      // R2: right first
      cyc("R2 right first", 1, 0, 0, 0, 1, 1, 2, 0, 0);
      cyc("R2 right first", 1, 1, 1, 2, 1, 1, 2, 0, 0);
      cyc("R6 busy lag", 1, 1, 1, 2, 1, 1, 2, 0, 0);
      cyc("R9 loser write", 1, 1, 1, 2, 1, 0, 2, 0, 0);
      cyc("R5 enable drop", 1, 1, 1, 2, 0, 0, 2, 0, 0);
      cyc("R5 enable drop", 1, 1, 1, 2, 0, 0, 2, 0, 0);
      cyc("R1 idle", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      // R3: same-cycle arrival
      cyc("R3 tie", 1, 1, 1, 6, 1, 1, 6, 0, 0);
      cyc("R3 tie", 1, 1, 1, 6, 1, 1, 6, 0, 0);
      cyc("R3 tie", 1, 1, 1, 6, 1, 1, 6, 0, 0);
      cyc("R3 tie move", 1, 1, 1, 1, 1, 1, 1, 0, 0);
      cyc("R3 tie move", 1, 1, 1, 1, 1, 1, 1, 0, 0);
      // R8: slave mode, local arbitration ignored
      cyc("R8 slave", 0, 1, 1, 4, 1, 1, 4, 0, 0);
      cyc("R8 slave", 0, 1, 1, 4, 1, 1, 4, 0, 1);
      cyc("R8 slave", 0, 1, 1, 4, 1, 1, 4, 1, 0);
      cyc("R8 slave", 0, 1, 1, 3, 1, 1, 4, 1, 1);
      cyc("R7 master again", 1, 0, 0, 0, 0, 0, 0, 1, 1);
      cyc("R7 master again", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      // R7: random run on a tiny address space
      for (int i = 0; i < 3000; i++) begin
         cyc("R7 random", ($urandom_range(0, 15) != 0),
             ($urandom_range(0, 3) != 0), 1'($urandom), $urandom_range(0, 3),
             ($urandom_range(0, 3) != 0), 1'($urandom), $urandom_range(0, 3),
             1'($urandom), 1'($urandom));
      end
      cyc("R7 random end", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R7 random end", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule